// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Manager

This block sits between a USB protocol engine and an internal DMA bus in a device with nine addressable endpoints. Each IN endpoint owns a word-wide packet FIFO. The DMA side fills it, and the transmitter drains it one word at a time on request. All OUT endpoints share a single receive FIFO. The protocol engine announces each received OUT packet with its endpoint number. The block answers one cycle later with accept or NAK. Once a packet is accepted, its data words are written and it is committed at the end of the packet.

Admission control reserves the worst case for the target endpoint before a single word is written. Overflow therefore cannot happen. A packet that ends in error, or runs past its limit, is rolled back to the write pointer saved at its start. Every committed packet is padded to a whole DMA burst of four words. A descriptor word carrying the endpoint number and byte count goes into a small companion queue, so the DMA side can split the shared stream by endpoint. Endpoint 0 works straight out of reset with a fixed limit and no configuration.

Top module: `usb_ep_buffer`

## Requirements
- R1: Endpoints are numbered 0 to 8. An OUT packet announced for endpoint 9 or above is NAKed, and an IN write addressed to endpoint 9 or above is dropped.
- R2: Endpoint 0 is accepted right after reset with no configuration, using a fixed limit of 16 data words (64 bytes).
- R3: An OUT packet for endpoint 1..8 is accepted only while that endpoint's enable bit in `cfg_out_en` is set (bit e-1 for endpoint e).
- R4: `rx_ack` or `rx_nak` pulses for one cycle, in the cycle after `rx_start`. Accept requires two things: the uncommitted space in the shared FIFO must be at least the endpoint's word limit rounded up to a multiple of 4, and the descriptor queue (4 entries) must not be full. After a NAK, nothing of that packet is stored.
- R5: The shared FIFO never overflows. A packet carrying more data words than its endpoint limit is discarded whole at `rx_end`. A limit of 0, or one above 128, counts as 128 words (field e-1 of `cfg_max_words`, 8 bits each).
- R6: On an error-free `rx_end`, a descriptor enters the queue. Bits 19:16 hold the endpoint and bits 9:0 hold `rx_bytes`; all other bits are 0. The data words follow in arrival order, padded with filler words to a multiple of 4.
- R7: A packet ending with `rx_err` leaves no descriptor and no data, and its space is returned.
- R8: `dma_rx_req` is high exactly when at least 4 committed words wait in the shared FIFO. Descriptors of empty packets alone do not raise it.
- R9: Each endpoint has its own 128-word IN FIFO in first-in first-out order. `tx_words` shows the fill level of the endpoint selected by `tx_ep`, and `tx_data` shows its head word.
- R10: `dma_tx_req[e]` is high exactly when IN FIFO e has at least 4 free words. A write to a full FIFO is dropped, and `tx_rd` on an empty FIFO has no effect.
- R11: Words of a packet still in progress are invisible on the DMA side until its `rx_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_out_en | input | 8 | OUT enable, bit e-1 for endpoint e |
| cfg_max_words | input | 64 | Word limit per endpoint 1..8, 8 bits each |
| rx_start | input | 1 | Start of a received OUT packet |
| rx_ep | input | 4 | Endpoint number, sampled with rx_start |
| rx_valid | input | 1 | A data word is present |
| rx_data | input | 32 | Received data word |
| rx_end | input | 1 | End of packet; carries no data word |
| rx_err | input | 1 | Packet failed, sampled with rx_end |
| rx_bytes | input | 10 | Packet byte count, sampled with rx_end |
| rx_ack | output | 1 | Packet accepted |
| rx_nak | output | 1 | Packet refused |
| dma_rx_req | output | 1 | A 4-word burst can be read |
| dma_rx_rd | input | 1 | Pop one word from the shared FIFO |
| dma_rx_data | output | 32 | Head word of the shared FIFO |
| dma_rx_hdr_valid | output | 1 | A descriptor is waiting |
| dma_rx_hdr | output | 32 | Head descriptor |
| dma_rx_hdr_pop | input | 1 | Pop the head descriptor |
| dma_tx_req | output | 9 | Per-endpoint room for a 4-word burst |
| dma_tx_wr | input | 1 | Write one word into an IN FIFO |
| dma_tx_ep | input | 4 | Target IN endpoint for dma_tx_wr |
| dma_tx_data | input | 32 | Word to write |
| tx_ep | input | 4 | IN endpoint selected by the transmitter |
| tx_rd | input | 1 | Pop one word of the selected IN FIFO |
| tx_data | output | 32 | Head word of the selected IN FIFO |
| tx_words | output | 8 | Fill level of the selected IN FIFO |

## Verification
A corrupted receive pointer shows up as a descriptor whose data words arrive shifted, or as padding that is missing, when the packet is drained. The commit and read paths are visible in the cycle after `rx_end`, so such a fault appears within one packet. A wrong space calculation flips an accept into a NAK, or the reverse, on `rx_ack`/`rx_nak` one cycle after `rx_start`. The bench therefore places packets so that the free space lands just above or just below the reservation. On the IN side, a wrong pointer gives the wrong word order, or a `tx_words` value that fails to stop at 128 or to stay at 0 after a read from an empty FIFO.

// File: rtl/usb_ep_buffer.sv
module usb_ep_buffer #(
  parameter int NUM_EP    = 9,
  parameter int DW        = 32,
  parameter int EPW       = 4,
  parameter int BCW       = 10,
  parameter int IN_DEPTH  = 128,
  parameter int OUT_DEPTH = 128,
  parameter int HDR_DEPTH = 4,
  parameter int BURST     = 4,
  parameter int EP0_WORDS = 16,
  localparam int IPW = $clog2(IN_DEPTH) + 1,
  localparam int OPW = $clog2(OUT_DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EP-1:1]         cfg_out_en,
  input  logic [(NUM_EP-1)*OPW-1:0] cfg_max_words,
  input  logic                      rx_start,
  input  logic [EPW-1:0]            rx_ep,
  input  logic                      rx_valid,
  input  logic [DW-1:0]             rx_data,
  input  logic                      rx_end,
  input  logic                      rx_err,
  input  logic [BCW-1:0]            rx_bytes,
  output logic                      rx_ack,
  output logic                      rx_nak,
  output logic                      dma_rx_req,
  input  logic                      dma_rx_rd,
  output logic [DW-1:0]             dma_rx_data,
  output logic                      dma_rx_hdr_valid,
  output logic [DW-1:0]             dma_rx_hdr,
  input  logic                      dma_rx_hdr_pop,
  output logic [NUM_EP-1:0]         dma_tx_req,
  input  logic                      dma_tx_wr,
  input  logic [EPW-1:0]            dma_tx_ep,
  input  logic [DW-1:0]             dma_tx_data,
  input  logic [EPW-1:0]            tx_ep,
  input  logic                      tx_rd,
  output logic [DW-1:0]             tx_data,
  output logic [IPW-1:0]            tx_words
);
  localparam int HPW = $clog2(HDR_DEPTH) + 1;
  localparam int AW  = $clog2(NUM_EP * IN_DEPTH);
  localparam logic [OPW-1:0] BMASK = OPW'(BURST - 1);

  function automatic logic [OPW-1:0] rnd(input logic [OPW-1:0] x);
    return (x + BMASK) & ~BMASK;
  endfunction

  // shared receive side
  logic [DW-1:0]  out_mem [OUT_DEPTH];
  logic [DW-1:0]  hdr_mem [HDR_DEPTH];
  logic [OPW-1:0] out_wr, out_cm, out_rd, fill, room, need, req_max, raw;
  logic [HPW-1:0] hdr_wp, hdr_rp;
  logic           in_pkt, ovr, en_ok, admit, hdr_full, out_we, commit;
  logic [EPW-1:0] cur_ep;
  logic [OPW-1:0] cur_max, cur_cnt;
  logic [DW-1:0]  hdr_word;

  always_comb begin
    raw   = '0;
    en_ok = (rx_ep == '0);
    for (int e = 1; e < NUM_EP; e++)
      if (rx_ep == EPW'(e)) begin
        raw   = cfg_max_words[(e-1)*OPW +: OPW];
        en_ok = cfg_out_en[e];
      end
    if (rx_ep == '0)
      req_max = OPW'(EP0_WORDS);
    else if (raw == '0 || raw > OPW'(OUT_DEPTH))
      req_max = OPW'(OUT_DEPTH);
    else
      req_max = raw;
  end

  assign fill     = out_cm - out_rd;
  assign room     = OPW'(OUT_DEPTH) - fill;
  assign need     = rnd(req_max);
  assign hdr_full = (hdr_wp - hdr_rp) == HPW'(HDR_DEPTH);
  assign admit    = en_ok && room >= need && !hdr_full;
  assign out_we   = in_pkt && rx_valid && !rx_end && cur_cnt < cur_max;
  assign commit   = in_pkt && rx_end && !rx_err && !ovr;

  always_comb begin
    hdr_word = '0;
    hdr_word[16 +: EPW]  = cur_ep;
    hdr_word[BCW-1:0]    = rx_bytes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ack  <= 1'b0;
      rx_nak  <= 1'b0;
      in_pkt  <= 1'b0;
      ovr     <= 1'b0;
      cur_ep  <= '0;
      cur_max <= '0;
      cur_cnt <= '0;
      out_wr  <= '0;
      out_cm  <= '0;
      out_rd  <= '0;
      hdr_wp  <= '0;
      hdr_rp  <= '0;
    end else begin
      rx_ack <= 1'b0;
      rx_nak <= 1'b0;
      if (!in_pkt && rx_start) begin
        if (admit) begin
          in_pkt  <= 1'b1;
          cur_ep  <= rx_ep;
          cur_max <= req_max;
          cur_cnt <= '0;
          ovr     <= 1'b0;
          rx_ack  <= 1'b1;
        end else begin
          rx_nak  <= 1'b1;
        end
      end
      if (out_we) begin
        out_wr  <= out_wr + 1'b1;
        cur_cnt <= cur_cnt + 1'b1;
      end else if (in_pkt && rx_valid && !rx_end) begin
        ovr <= 1'b1;
      end
      if (in_pkt && rx_end) begin
        in_pkt <= 1'b0;
        if (commit) begin
          out_wr <= rnd(out_wr);
          out_cm <= rnd(out_wr);
          hdr_wp <= hdr_wp + 1'b1;
        end else begin
          out_wr <= out_cm;
        end
      end
      if (dma_rx_rd && fill != '0)
        out_rd <= out_rd + 1'b1;
      if (dma_rx_hdr_pop && hdr_wp != hdr_rp)
        hdr_rp <= hdr_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (out_we) out_mem[out_wr[OPW-2:0]] <= rx_data;
    if (commit) hdr_mem[hdr_wp[HPW-2:0]] <= hdr_word;
  end

  assign dma_rx_req       = fill >= OPW'(BURST);
  assign dma_rx_data      = out_mem[out_rd[OPW-2:0]];
  assign dma_rx_hdr_valid = hdr_wp != hdr_rp;
  assign dma_rx_hdr       = hdr_mem[hdr_rp[HPW-2:0]];

  // per-endpoint transmit side
  logic [DW-1:0]     in_mem [NUM_EP*IN_DEPTH];
  logic [IPW-1:0]    in_wp [NUM_EP];
  logic [IPW-1:0]    in_rp [NUM_EP];
  logic [IPW-1:0]    in_fill [NUM_EP];
  logic [NUM_EP-1:0] wr_sel, rd_sel;

  always_comb begin
    tx_words = '0;
    tx_data  = '0;
    for (int e = 0; e < NUM_EP; e++) begin
      in_fill[e]    = in_wp[e] - in_rp[e];
      dma_tx_req[e] = (IPW'(IN_DEPTH) - in_fill[e]) >= IPW'(BURST);
      wr_sel[e]     = dma_tx_wr && dma_tx_ep == EPW'(e) && in_fill[e] != IPW'(IN_DEPTH);
      rd_sel[e]     = tx_rd && tx_ep == EPW'(e) && in_fill[e] != '0;
      if (tx_ep == EPW'(e)) begin
        tx_words = in_fill[e];
        tx_data  = in_mem[AW'(e*IN_DEPTH) + AW'(in_rp[e][IPW-2:0])];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_EP; e++) begin
        in_wp[e] <= '0;
        in_rp[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (wr_sel[e]) in_wp[e] <= in_wp[e] + 1'b1;
        if (rd_sel[e]) in_rp[e] <= in_rp[e] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_EP; e++)
      if (wr_sel[e]) in_mem[AW'(e*IN_DEPTH) + AW'(in_wp[e][IPW-2:0])] <= dma_tx_data;
  end

  // checks
  p_range_nak_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && !in_pkt && rx_ep >= EPW'(NUM_EP)) |=> rx_nak);
  p_ep0_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && !in_pkt && rx_ep == '0 && out_cm == out_rd && hdr_wp == hdr_rp) |=> rx_ack);
  p_one_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ack && rx_nak));
  p_nak_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nak |-> (out_wr == out_cm && !in_pkt));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr - out_rd) <= OPW'(OUT_DEPTH));
  p_burst_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cm & BMASK) == '0);
  p_hdr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_wp - hdr_rp) <= HPW'(HDR_DEPTH));
  p_rollback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && rx_end && rx_err) |=> (out_wr == out_cm && $stable(out_cm) && $stable(hdr_wp)));
  p_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && !rx_end) |=> $stable(out_cm));

  for (genvar g = 0; g < NUM_EP; g++) begin : g_in_chk
    p_in_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wp[g] - in_rp[g]) <= IPW'(IN_DEPTH));
  end
endmodule

// File: tb/usb_ep_buffer_tb.sv
module usb_ep_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:1]  cfg_out_en = '0;
  logic [63:0] cfg_max_words = '0;
  logic        rx_start = 0, rx_valid = 0, rx_end = 0, rx_err = 0;
  logic [3:0]  rx_ep = '0;
  logic [31:0] rx_data = '0;
  logic [9:0]  rx_bytes = '0;
  logic        rx_ack, rx_nak, dma_rx_req, dma_rx_hdr_valid;
  logic        dma_rx_rd = 0, dma_rx_hdr_pop = 0;
  logic [31:0] dma_rx_data, dma_rx_hdr;
  logic [8:0]  dma_tx_req;
  logic        dma_tx_wr = 0, tx_rd = 0;
  logic [3:0]  dma_tx_ep = '0, tx_ep = '0;
  logic [31:0] dma_tx_data = '0, tx_data;
  logic [7:0]  tx_words;

  int nchk = 0, nfail = 0;
  bit ack, nak;

  always #4 clk = ~clk;

  usb_ep_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_out_en(cfg_out_en), .cfg_max_words(cfg_max_words),
    .rx_start(rx_start), .rx_ep(rx_ep), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_end(rx_end), .rx_err(rx_err), .rx_bytes(rx_bytes), .rx_ack(rx_ack), .rx_nak(rx_nak),
    .dma_rx_req(dma_rx_req), .dma_rx_rd(dma_rx_rd), .dma_rx_data(dma_rx_data),
    .dma_rx_hdr_valid(dma_rx_hdr_valid), .dma_rx_hdr(dma_rx_hdr), .dma_rx_hdr_pop(dma_rx_hdr_pop),
    .dma_tx_req(dma_tx_req), .dma_tx_wr(dma_tx_wr), .dma_tx_ep(dma_tx_ep),
    .dma_tx_data(dma_tx_data), .tx_ep(tx_ep), .tx_rd(tx_rd), .tx_data(tx_data), .tx_words(tx_words)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic send_out(input int ep, input int nw, input int bytes, input bit err,
                          input int base, input bit vis);
    rx_start = 1; rx_ep = 4'(ep);
    @(negedge clk);
    rx_start = 0;
    ack = rx_ack; nak = rx_nak;
    for (int i = 0; i < nw; i++) begin
      rx_valid = 1; rx_data = 32'(base + i);
      @(negedge clk);
    end
    rx_valid = 0;
    if (vis) chk("R11 invisible before end", {30'd0, dma_rx_req, dma_rx_hdr_valid}, 0);
    rx_end = 1; rx_err = err; rx_bytes = 10'(bytes);
    @(negedge clk);
    rx_end = 0; rx_err = 0;
  endtask

  task automatic rd_pkt(input string tag, input int ep, input int bytes, input int nw, input int base);
    chk({tag, " hdr valid"}, 32'(dma_rx_hdr_valid), 1);
    chk({tag, " hdr"}, dma_rx_hdr, 32'((ep << 16) | bytes));
    for (int i = 0; i < ((nw + 3) / 4) * 4; i++) begin
      if (i < nw) chk({tag, " data"}, dma_rx_data, 32'(base + i));
      dma_rx_rd = 1;
      @(negedge clk);
    end
    dma_rx_rd = 0;
    dma_rx_hdr_pop = 1;
    @(negedge clk);
    dma_rx_hdr_pop = 0;
  endtask

  task automatic wr_in(input int ep, input int val);
    dma_tx_wr = 1; dma_tx_ep = 4'(ep); dma_tx_data = 32'(val);
    @(negedge clk);
    dma_tx_wr = 0;
  endtask

  task automatic rd_in(input string tag, input int ep, input int exp);
    tx_ep = 4'(ep);
    #1 chk(tag, tx_data, 32'(exp));
    tx_rd = 1;
    @(negedge clk);
    tx_rd = 0;
  endtask

  task automatic t_reset;
    chk("R4 reset ack/nak", {30'd0, rx_ack, rx_nak}, 0);
    chk("R8 reset rx req", 32'(dma_rx_req), 0);
    chk("R6 reset hdr", 32'(dma_rx_hdr_valid), 0);
    chk("R10 reset tx req", 32'(dma_tx_req), 32'h1FF);
    chk("R9 reset level", 32'(tx_words), 0);
  endtask

  task automatic t_ep0;
    send_out(0, 3, 10, 0, 32'h100, 1);
    chk("R2 ep0 ack", {30'd0, ack, nak}, 2);
    chk("R8 padded burst ready", 32'(dma_rx_req), 1);
    rd_pkt("R6 ep0 pkt", 0, 10, 3, 32'h100);
    chk("R8 req drops", 32'(dma_rx_req), 0);
  endtask

  task automatic t_refuse;
    send_out(3, 2, 8, 0, 32'h200, 0);
    chk("R3 disabled nak", {30'd0, ack, nak}, 1);
    send_out(9, 2, 8, 0, 32'h300, 0);
    chk("R1 ep9 nak", {30'd0, ack, nak}, 1);
    chk("R4 nak stores nothing", {30'd0, dma_rx_req, dma_rx_hdr_valid}, 0);
  endtask

  task automatic t_admission;
    cfg_out_en[2] = 1;
    cfg_max_words[15:8] = 8'd128;
    send_out(2, 5, 20, 0, 32'h400, 1);
    chk("R3 enabled ack", {30'd0, ack, nak}, 2);
    send_out(2, 1, 4, 0, 32'h500, 0);
    chk("R4 no room nak", {30'd0, ack, nak}, 1);
    send_out(0, 2, 8, 0, 32'h600, 0);
    chk("R4 small fits ack", {30'd0, ack, nak}, 2);
    rd_pkt("R6 first", 2, 20, 5, 32'h400);
    rd_pkt("R6 second", 0, 8, 2, 32'h600);
    chk("R8 drained", 32'(dma_rx_req), 0);
  endtask

  task automatic t_error;
    send_out(0, 4, 16, 1, 32'h700, 0);
    chk("R7 err ack at start", {30'd0, ack, nak}, 2);
    chk("R7 nothing visible", {30'd0, dma_rx_req, dma_rx_hdr_valid}, 0);
    send_out(0, 1, 2, 0, 32'h800, 0);
    rd_pkt("R7 next pkt clean", 0, 2, 1, 32'h800);
  endtask

  task automatic t_overrun;
    cfg_out_en[1] = 1;
    cfg_max_words[7:0] = 8'd2;
    send_out(1, 3, 12, 0, 32'h900, 0);
    chk("R5 overrun ack", {30'd0, ack, nak}, 2);
    chk("R5 overrun dropped", {30'd0, dma_rx_req, dma_rx_hdr_valid}, 0);
    send_out(1, 2, 8, 0, 32'hA00, 0);
    rd_pkt("R5 limit exact", 1, 8, 2, 32'hA00);
  endtask

  task automatic t_hdr_full;
    for (int i = 0; i < 4; i++) begin
      send_out(0, 0, 0, 0, 0, 0);
      chk("R4 zlp ack", {30'd0, ack, nak}, 2);
    end
    chk("R8 zlp no req", 32'(dma_rx_req), 0);
    send_out(0, 0, 0, 0, 0, 0);
    chk("R4 hdr queue full nak", {30'd0, ack, nak}, 1);
    for (int i = 0; i < 4; i++) rd_pkt("R6 zlp", 0, 0, 0, 0);
    chk("R6 queue empty", 32'(dma_rx_hdr_valid), 0);
  endtask

  task automatic t_in_basic;
    for (int i = 0; i < 5; i++) wr_in(4, 32'h4000 + i);
    wr_in(7, 32'h7000);
    wr_in(7, 32'h7001);
    wr_in(9, 32'h9999);
    tx_ep = 4;
    #1 chk("R9 level ep4", 32'(tx_words), 5);
    tx_ep = 7;
    #1 chk("R9 level ep7", 32'(tx_words), 2);
    for (int e = 0; e < 9; e++) if (e != 4 && e != 7) begin
      tx_ep = 4'(e);
      #1 chk("R1 ep9 write dropped", 32'(tx_words), 0);
    end
    rd_in("R9 ep7 order", 7, 32'h7000);
    for (int i = 0; i < 5; i++) rd_in("R9 ep4 order", 4, 32'h4000 + i);
    rd_in("R9 ep7 order", 7, 32'h7001);
  endtask

  task automatic t_in_full;
    for (int i = 0; i < 124; i++) wr_in(1, 32'h1000 + i);
    chk("R10 four free", 32'(dma_tx_req[1]), 1);
    wr_in(1, 32'h1000 + 124);
    chk("R10 three free", 32'(dma_tx_req[1]), 0);
    for (int i = 125; i < 129; i++) wr_in(1, 32'h1000 + i);
    tx_ep = 1;
    #1 chk("R10 full level", 32'(tx_words), 128);
    for (int i = 0; i < 128; i++) rd_in("R10 full data", 1, 32'h1000 + i);
    rd_in("R10 empty read", 1, 32'h1000);
    #1 chk("R10 empty stays", 32'(tx_words), 0);
    wr_in(1, 32'hBEEF);
    rd_in("R10 after empty read", 1, 32'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ep0;
    t_refuse;
    t_admission;
    t_error;
    t_overrun;
    t_hdr_full;
    t_in_basic;
    t_in_full;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule